// File: doc/BRIEF.md
# Wide Add/Subtract Unit with Dual Flag Groups

This block is the add/subtract stage of a 256-bit big-number datapath. On each cycle where its valid strobe is high, it takes two wide operands. It passes the second operand through a byte-granular logical pre-shift, then either adds the operands or subtracts the second from the first. A carry or borrow input can join the operation. The 256-bit result is registered and presented on the output.

Every operation also writes a four-bit flag group. The flags record the carry/borrow out, the top result bit, the bottom result bit and whether the result is zero. Two independent groups exist and a select input picks which one an operation writes. When carry chaining is enabled, the carry or borrow input comes from the C flag of that same selected group. The C flag is read before the operation updates it, so multi-word arithmetic can be issued as back-to-back operations that use the same group.

Top module: `wide_alu_flags`

## Requirements
- R1: With `op_sub_i`=0, the result registered on a valid cycle equals (A + B' + cin) mod 2^256, where B' is the pre-shifted second operand and cin is the carry input.
- R2: With `op_sub_i`=1, the result registered on a valid cycle equals (A − B' − cin) mod 2^256.
- R3: With `shift_right_i`=0, B' is B shifted left by 8×`shift_bytes_i` bits, and zeros fill the vacated low bits. An amount of 0 leaves B unchanged.
- R4: With `shift_right_i`=1, B' is B shifted right by 8×`shift_bytes_i` bits, and zeros fill the vacated high bits.
- R5: Flag bit 0 (C) takes bit 256 of the 257-bit extended sum. For an add this is the carry out. For a subtract it is 1 when A < B' + cin.
- R6: Flag bit 1 (M) takes result bit 255, and flag bit 2 (L) takes result bit 0.
- R7: Flag bit 3 (Z) is 1 exactly when all 256 result bits are zero.
- R8: A valid operation writes only the group chosen by `group_sel_i` (0 selects `flags0_o`, 1 selects `flags1_o`). The other group keeps its value.
- R9: When `use_carry_i`=0, cin is 0. When it is 1, cin is the C flag of the selected group as it stood before the operation.
- R10: On a cycle with `valid_i`=0, the result and both flag groups keep their values, whatever the other inputs are.
- R11: While `rst` is high at a clock edge, the result and both flag groups are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Perform an operation this cycle |
| op_sub_i | input | 1 | 0 = add, 1 = subtract |
| use_carry_i | input | 1 | Take carry/borrow in from the selected group's C flag |
| shift_right_i | input | 1 | Pre-shift direction: 0 = left, 1 = right |
| shift_bytes_i | input | 5 | Pre-shift amount in bytes (0 to 31) |
| group_sel_i | input | 1 | Flag group to read the carry from and to write |
| opa_i | input | 256 | First operand |
| opb_i | input | 256 | Second operand (pre-shifted) |
| result_o | output | 256 | Registered result |
| flags0_o | output | 4 | Flag group 0: {Z, L, M, C} |
| flags1_o | output | 4 | Flag group 1: {Z, L, M, C} |

## Verification
Directed cases come first. They target the extremes of the arithmetic: an all-ones add that wraps to zero, which separates the C and Z flags, and a zero-minus-one subtract, which shows a borrow together with M and L. Chained operations with the carry enabled follow, once with a set C flag and once with a clear one. They show that the carry comes from the selected group and not from the other group. Shifts of 31 bytes in both directions and a one-byte right shift check the direction and the zero fill. A valid-low cycle with different inputs checks that everything holds. After that, a long run of mixed random operations, shifts, groups and carry settings is compared every cycle against a behavioural model.

// File: rtl/wide_alu_pkg.sv
package wide_alu_pkg;

    parameter int DATA_W  = 256;
    parameter int SHAMT_W = 5;
    parameter int NGROUPS = 2;
    localparam int GSEL_W = (NGROUPS > 1) ? $clog2(NGROUPS) : 1;

    typedef enum logic { OP_ADD = 1'b0, OP_SUB = 1'b1 } alu_op_e;
    typedef enum logic { SH_LEFT = 1'b0, SH_RIGHT = 1'b1 } shift_dir_e;

    // Bit 0 carry, bit 1 msb, bit 2 lsb, bit 3 zero
    typedef struct packed {
        logic z;
        logic l;
        logic m;
        logic c;
    } flags_t;

    typedef struct packed {
        alu_op_e              op;
        logic                 use_carry;
        shift_dir_e           dir;
        logic [SHAMT_W-1:0]   amt;
        logic [GSEL_W-1:0]    grp;
    } alu_ctrl_t;

    function automatic flags_t derive_flags(input logic [DATA_W:0] ext);
        flags_t f;
        f.c = ext[DATA_W];
        f.m = ext[DATA_W-1];
        f.l = ext[0];
        f.z = (ext[DATA_W-1:0] == '0);
        return f;
    endfunction

endpackage

// File: rtl/byte_shifter.sv
module byte_shifter
    import wide_alu_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int AMTW = SHAMT_W
) (
    input  logic [W-1:0]    din,
    input  shift_dir_e      dir,
    input  logic [AMTW-1:0] amt,
    output logic [W-1:0]    dout
);
    // One stage per amount bit; stage k moves by 2^k bytes
    logic [W-1:0] stage [0:AMTW];
    assign stage[0] = din;

    for (genvar k = 0; k < AMTW; k++) begin : g_stage
        localparam int BITS = 8 << k;
        logic [W-1:0] moved;
        assign moved = (dir == SH_RIGHT) ? (stage[k] >> BITS) : (stage[k] << BITS);
        assign stage[k+1] = amt[k] ? moved : stage[k];
    end

    assign dout = stage[AMTW];
endmodule

// File: rtl/add_sub_core.sv
module add_sub_core
    import wide_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  alu_op_e      op,
    output logic [W-1:0] sum,
    output flags_t       flags
);
    localparam int EW = W + 1;
    logic [EW-1:0] ext_a, ext_b, ext_c, ext;

    assign ext_a = {1'b0, a};
    assign ext_b = {1'b0, b};
    assign ext_c = {{W{1'b0}}, cin};

    always_comb begin
        if (op == OP_SUB) ext = ext_a - ext_b - ext_c;
        else              ext = ext_a + ext_b + ext_c;
    end

    assign sum   = ext[W-1:0];
    assign flags = derive_flags(ext);
endmodule

// File: rtl/flag_bank.sv
module flag_bank
    import wide_alu_pkg::*;
#(
    parameter int NG = NGROUPS,
    parameter int SW = GSEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [SW-1:0]       sel,
    input  flags_t              wdata,
    output logic                c_sel,
    output logic [NG-1:0][3:0]  q
);
    flags_t grp_q [NG];

    for (genvar g = 0; g < NG; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst)                             grp_q[g] <= '0;
            else if (we && (sel == SW'(g)))      grp_q[g] <= wdata;
        end
        assign q[g] = grp_q[g];

        // R8: a group not selected by a write holds its value
        a_r8_unselected_hold: assert property (@(posedge clk) disable iff (rst)
            (we && (sel != SW'(g))) |=> $stable(q[g]));
    end

    always_comb begin
        c_sel = 1'b0;
        for (int g = 0; g < NG; g++)
            if (sel == SW'(g)) c_sel = grp_q[g].c;
    end
endmodule

// File: rtl/wide_alu_flags.sv
module wide_alu_flags
    import wide_alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_i,
    input  logic                op_sub_i,
    input  logic                use_carry_i,
    input  logic                shift_right_i,
    input  logic [SHAMT_W-1:0]  shift_bytes_i,
    input  logic                group_sel_i,
    input  logic [DATA_W-1:0]   opa_i,
    input  logic [DATA_W-1:0]   opb_i,
    output logic [DATA_W-1:0]   result_o,
    output logic [3:0]          flags0_o,
    output logic [3:0]          flags1_o
);
    alu_ctrl_t            ctrl;
    logic [DATA_W-1:0]    b_shifted;
    logic [DATA_W-1:0]    sum;
    flags_t               new_flags;
    logic                 c_sel;
    logic                 cin;
    logic [DATA_W-1:0]    result_q;
    logic [NGROUPS-1:0][3:0] bank_q;

    assign ctrl.op        = alu_op_e'(op_sub_i);
    assign ctrl.use_carry = use_carry_i;
    assign ctrl.dir       = shift_dir_e'(shift_right_i);
    assign ctrl.amt       = shift_bytes_i;
    assign ctrl.grp       = GSEL_W'(group_sel_i);

    byte_shifter #(.W(DATA_W), .AMTW(SHAMT_W)) u_shift (
        .din (opb_i),
        .dir (ctrl.dir),
        .amt (ctrl.amt),
        .dout(b_shifted)
    );

    // Carry/borrow in from the selected group's pre-operation C flag
    assign cin = ctrl.use_carry & c_sel;

    add_sub_core #(.W(DATA_W)) u_core (
        .a    (opa_i),
        .b    (b_shifted),
        .cin  (cin),
        .op   (ctrl.op),
        .sum  (sum),
        .flags(new_flags)
    );

    flag_bank #(.NG(NGROUPS), .SW(GSEL_W)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .we   (valid_i),
        .sel  (ctrl.grp),
        .wdata(new_flags),
        .c_sel(c_sel),
        .q    (bank_q)
    );

    always_ff @(posedge clk) begin
        if (rst)          result_q <= '0;
        else if (valid_i) result_q <= sum;
    end

    assign result_o = result_q;
    assign flags0_o = bank_q[0];
    assign flags1_o = bank_q[1];

    // R10: idle cycles change nothing
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(result_o) && $stable(flags0_o) && $stable(flags1_o)));

    // R7: zero flag of the written group agrees with the registered result
    a_r7_zero_tracks: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !group_sel_i) |=> (flags0_o[3] == (result_o == '0)));

    // R6: lsb/msb flags of the written group mirror result bits
    a_r6_edge_bits: assert property (@(posedge clk) disable iff (rst)
        (valid_i && group_sel_i) |=> (flags1_o[2] == result_o[0] && flags1_o[1] == result_o[DATA_W-1]));

    // R11: reset clears all state
    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (result_o == '0 && flags0_o == 4'd0 && flags1_o == 4'd0));
endmodule

// File: tb/sim_wide_alu_flags.sv
`timescale 1ns/1ps
module sim_wide_alu_flags;
    logic         clk = 1'b0;
    logic         rst;
    logic         valid_i, op_sub_i, use_carry_i, shift_right_i, group_sel_i;
    logic [4:0]   shift_bytes_i;
    logic [255:0] opa_i, opb_i;
    logic [255:0] result_o;
    logic [3:0]   flags0_o, flags1_o;

    int checks = 0;
    int errors = 0;

    logic [255:0] exp_res;
    logic [3:0]   exp_f [2];

    always #2.5 clk = ~clk;

    wide_alu_flags u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_sub_i(op_sub_i),
        .use_carry_i(use_carry_i), .shift_right_i(shift_right_i),
        .shift_bytes_i(shift_bytes_i), .group_sel_i(group_sel_i),
        .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o),
        .flags0_o(flags0_o), .flags1_o(flags1_o)
    );

    task automatic chk_vec(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s result act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag, input int g, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s flags%0d act=%b exp=%b", tag, g, act, exp);
        end
    endtask

    // Drive one cycle, advance the reference model, compare at the next falling edge
    task automatic step(input bit v, input bit sub, input bit uc, input bit sr,
                        input logic [4:0] amt, input bit g,
                        input logic [255:0] a, input logic [255:0] b, input string tag);
        logic [255:0] bs;
        logic [256:0] ext;
        logic         cin;
        valid_i = v; op_sub_i = sub; use_carry_i = uc; shift_right_i = sr;
        shift_bytes_i = amt; group_sel_i = g; opa_i = a; opb_i = b;
        if (v) begin
            bs  = sr ? (b >> (8 * amt)) : (b << (8 * amt));
            cin = uc ? exp_f[g][0] : 1'b0;
            if (sub) ext = {1'b0, a} - {1'b0, bs} - 257'(cin);
            else     ext = {1'b0, a} + {1'b0, bs} + 257'(cin);
            exp_res  = ext[255:0];
            exp_f[g] = {(ext[255:0] == 0), ext[0], ext[255], ext[256]};
        end
        @(posedge clk);
        @(negedge clk);
        chk_vec(tag, result_o, exp_res);
        chk_flags(tag, 0, flags0_o, exp_f[0]);
        chk_flags(tag, 1, flags1_o, exp_f[1]);
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    localparam logic [255:0] ONES = {256{1'b1}};

    initial begin
        rst = 1'b1; valid_i = 0; op_sub_i = 0; use_carry_i = 0; shift_right_i = 0;
        shift_bytes_i = '0; group_sel_i = 0; opa_i = '0; opb_i = '0;
        exp_res = '0; exp_f[0] = '0; exp_f[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk_vec("R11", result_o, '0);
        chk_flags("R11", 0, flags0_o, 4'b0000);
        chk_flags("R11", 1, flags1_o, 4'b0000);

        step(1, 0, 0, 0, 0, 0, 256'd5, 256'd7, "R1");
        // wrap to zero: C=1, Z=1
        step(1, 0, 0, 0, 0, 0, ONES, 256'd1, "R5");
        chk_flags("R7", 0, flags0_o, 4'b1001);
        // borrow: all ones, C, M, L set; group 0 untouched
        step(1, 1, 0, 0, 0, 1, 256'd0, 256'd1, "R2");
        chk_flags("R6", 1, flags1_o, 4'b0111);
        chk_flags("R8", 0, flags0_o, 4'b1001);
        // carry chained from each group's own C
        step(1, 0, 1, 0, 0, 0, 256'd1, 256'd1, "R9");
        chk_vec("R9", result_o, 256'd3);
        step(1, 1, 1, 0, 0, 1, 256'd10, 256'd3, "R9");
        chk_vec("R9", result_o, 256'd6);
        step(1, 0, 1, 0, 0, 0, 256'd1, 256'd1, "R9");
        chk_vec("R9", result_o, 256'd2);
        // pre-shifts
        step(1, 0, 0, 0, 5'd31, 0, 256'd0, 256'hAB, "R3");
        chk_vec("R3", result_o, {8'hAB, 248'd0});
        step(1, 0, 0, 1, 5'd31, 1, 256'd0, {8'hCD, 248'hFF}, "R4");
        chk_vec("R4", result_o, 256'hCD);
        step(1, 0, 0, 1, 5'd1, 1, 256'd0, 256'h1234, "R4");
        chk_vec("R4", result_o, 256'h12);
        // idle cycle with changed inputs
        step(0, 1, 1, 1, 5'd7, 0, ONES, ONES, "R10");
        chk_vec("R10", result_o, 256'h12);

        for (int n = 0; n < 400; n++) begin
            logic s = 1'($urandom);
            step(($urandom % 8) != 0, s, 1'($urandom), 1'($urandom),
                 5'($urandom), 1'($urandom), rnd256(),
                 (($urandom % 4) == 0) ? rnd256() >> 200 : rnd256(),
                 s ? "R2" : "R1");
        end

        // mid-run reset
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        exp_res = '0; exp_f[0] = '0; exp_f[1] = '0;
        chk_vec("R11", result_o, '0);
        chk_flags("R11", 0, flags0_o, 4'b0000);
        chk_flags("R11", 1, flags1_o, 4'b0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule